// File: doc/BRIEF.md
# LED Matrix Refresh Engine

This block keeps a 5x5 LED matrix lit from a picture held in ordinary RAM. Each cell has sixteen grey levels, from 0 (dark) up to 15 (brightest). At the start of every frame the engine reads a one-byte frame pointer from a fixed pointer cell at address 0x1A. It then fetches the brightness bytes starting at the address the pointer names. Software can therefore move the picture to a new place by rewriting one byte. The picture normally sits at the bottom of memory, at 0x00.

The matrix is scanned one row at a time. While a row is lit, each of its columns is pulse-width modulated over sixteen time slots, and the length of a slot is set by a prescaler parameter. The engine reads the five bytes for the next row into a shadow buffer while the current row is lit. It shares a single read port with the CPU, and it issues a read only in cycles when the CPU leaves the port free.

Two state machines do the work. The fetch machine has the states FS_IDLE, FS_PTR_REQ, FS_PTR_WAIT, FS_CELL_REQ and FS_CELL_WAIT:
- FS_IDLE goes to FS_PTR_REQ when the shadow is empty and row 0 is next, and to FS_CELL_REQ when it is empty and any other row is next.
- A REQ state moves to its WAIT state once a read is accepted.
- FS_PTR_WAIT goes to FS_CELL_REQ.
- FS_CELL_WAIT goes back to FS_CELL_REQ until the fifth byte of the row has arrived, and then to FS_IDLE.

The scan machine has the states SC_BLANK and SC_LIT:
- It goes to SC_LIT whenever a full shadow is taken over, either from SC_BLANK or at the end of a row.
- It goes from SC_LIT to SC_BLANK when a row ends and no shadow is ready.

Top module: `ledmx_refresh`

## Requirements
- R1: While rst_n is low, row_en, col_on and mem_req are all 0.
- R2: The first read of each frame is of the pointer cell at address 0x1A. The byte read becomes the base address for the five rows that follow. A change to the pointer therefore takes effect at the next frame and does not affect the rows still to come in the current frame.
- R3: The cell at row r, column c is read from address (base + 5*r + c) modulo 256. Only bits 3:0 of that byte are the brightness, and bits 7:4 are ignored.
- R4: Slot s runs from 0 to 15 within a lit row. Column c is on during slot s exactly when its brightness is greater than s. A column therefore stays on for brightness × PRESCALE cycles per row visit: level 0 never lights it, and level 15 lights it for 15 of the 16 slots.
- R5: Each row visit lasts exactly 16 × PRESCALE cycles. Rows are visited in the order 0, 1, 2, 3, 4, 0, and so on, and while the bus is free one row follows the next with no gap.
- R6: At most one bit of row_en is set at a time. When row_en is 0, col_on is 0 as well.
- R7: mem_req is never 1 in a cycle where cpu_busy is 1. Read data is taken from mem_rdata one cycle after a read is accepted.
- R8: If the next row's five bytes have not all been read when the current row ends, the matrix stays dark until they have been read. Display then resumes with that row, for a full row visit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_busy | input | 1 | The CPU is using the shared read port in this cycle |
| mem_req | output | 1 | Read request by the engine, accepted in the same cycle |
| mem_addr | output | 8 | Address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after an accepted request |
| row_en | output | 5 | One-hot row enable, all zero when the matrix is dark |
| col_on | output | 5 | Column drive for the lit row |

## Verification
The hardest case to reach is starvation, where the CPU takes the port before the next row's bytes have been fetched. This is the only case that blanks the matrix in the middle of a frame. To reach it, the bench raises cpu_busy in the very first cycle of a row, before the fetch machine has left FS_IDLE. It holds cpu_busy for longer than one row visit and checks that the matrix goes dark and that no read is issued while the CPU holds the port. It then releases the port and checks that display resumes with the row that was starved, not a repeat of the previous one. A change of pointer made during row 1 is checked separately: the later rows of that frame must still use the old base, and the whole of the next frame must use the new one.

// File: rtl/ledmx_pkg.sv
package ledmx_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_PTR_REQ,
        FS_PTR_WAIT,
        FS_CELL_REQ,
        FS_CELL_WAIT
    } fetch_state_e;

    typedef enum logic {
        SC_BLANK,
        SC_LIT
    } scan_state_e;

endpackage

// File: rtl/ledmx_fetch.sv
module ledmx_fetch
    import ledmx_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] PTR_ADDR = 'h1A,
    parameter int ROWS     = 5,
    parameter int COLS     = 5,
    parameter int LEVEL_W  = 4,
    parameter int ROW_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_busy,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic [ADDR_W-1:0]        mem_rdata,
    input  logic                     take,
    output logic                     shadow_full,
    output logic [ROW_W-1:0]         shadow_row,
    output logic [COLS*LEVEL_W-1:0]  shadow_lvl
);
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

    fetch_state_e            state_q, state_d;
    logic [ADDR_W-1:0]       addr_q;
    logic [COL_W-1:0]        col_q;
    logic [ROW_W-1:0]        row_q;
    logic [ROW_W-1:0]        srow_q;
    logic                    full_q;
    logic [LEVEL_W-1:0]      shadow_q [COLS];
    logic                    last_col;

    assign last_col = (col_q == COL_W'(COLS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // next state and port outputs
    always_comb begin
        state_d  = state_q;
        mem_req  = 1'b0;
        mem_addr = addr_q;
        unique case (state_q)
            FS_IDLE: begin
                if (!full_q)
                    state_d = (row_q == '0) ? FS_PTR_REQ : FS_CELL_REQ;
            end
            FS_PTR_REQ: begin
                mem_addr = PTR_ADDR;
                mem_req  = !cpu_busy;
                if (!cpu_busy) state_d = FS_PTR_WAIT;
            end
            FS_PTR_WAIT: state_d = FS_CELL_REQ;
            FS_CELL_REQ: begin
                mem_req = !cpu_busy;
                if (!cpu_busy) state_d = FS_CELL_WAIT;
            end
            FS_CELL_WAIT: state_d = last_col ? FS_IDLE : FS_CELL_REQ;
            default: state_d = FS_IDLE;
        endcase
    end

    // datapath: address walk, shadow capture, full flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            col_q  <= '0;
            row_q  <= '0;
            srow_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (take) full_q <= 1'b0;
            if (state_q == FS_PTR_WAIT) begin
                addr_q <= mem_rdata;
                col_q  <= '0;
            end
            if (state_q == FS_CELL_WAIT) begin
                addr_q <= addr_q + 1'b1;
                if (last_col) begin
                    col_q  <= '0;
                    full_q <= 1'b1;
                    srow_q <= row_q;
                    row_q  <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_shadow
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_q[c] <= '0;
            else if (state_q == FS_CELL_WAIT && col_q == COL_W'(c))
                shadow_q[c] <= mem_rdata[LEVEL_W-1:0];
        end
        assign shadow_lvl[c*LEVEL_W +: LEVEL_W] = shadow_q[c];
    end

    assign shadow_full = full_q;
    assign shadow_row  = srow_q;

endmodule

// File: rtl/ledmx_scan.sv
module ledmx_scan
    import ledmx_pkg::*;
#(
    parameter int ROWS     = 5,
    parameter int COLS     = 5,
    parameter int LEVEL_W  = 4,
    parameter int PRESCALE = 64,
    parameter int ROW_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shadow_full,
    input  logic [ROW_W-1:0]         shadow_row,
    input  logic [COLS*LEVEL_W-1:0]  shadow_lvl,
    output logic                     take,
    output logic                     lit,
    output logic [LEVEL_W-1:0]       slot,
    output logic [COLS*LEVEL_W-1:0]  active_lvl,
    output logic [ROWS-1:0]          row_en
);
    localparam int PRESC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    scan_state_e             state_q, state_d;
    logic [ROW_W-1:0]        row_q;
    logic [LEVEL_W-1:0]      slot_q;
    logic [PRESC_W-1:0]      presc_q;
    logic [COLS*LEVEL_W-1:0] act_q;
    logic                    slot_end, row_end;

    assign slot_end = (presc_q == PRESC_W'(PRESCALE - 1));
    assign row_end  = (state_q == SC_LIT) && slot_end && (slot_q == '1);
    assign take     = shadow_full && ((state_q == SC_BLANK) || row_end);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SC_BLANK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_BLANK: if (take) state_d = SC_LIT;
            SC_LIT:   if (row_end) state_d = take ? SC_LIT : SC_BLANK;
            default:  state_d = SC_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            slot_q  <= '0;
            presc_q <= '0;
            act_q   <= '0;
        end else if (take) begin
            row_q   <= shadow_row;
            act_q   <= shadow_lvl;
            slot_q  <= '0;
            presc_q <= '0;
        end else if (state_q == SC_LIT) begin
            if (slot_end) begin
                presc_q <= '0;
                slot_q  <= slot_q + 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        lit        = (state_q == SC_LIT);
        slot       = slot_q;
        active_lvl = act_q;
        row_en     = '0;
        if (state_q == SC_LIT) row_en[row_q] = 1'b1;
    end

endmodule

// File: rtl/ledmx_cell_pwm.sv
module ledmx_cell_pwm #(
    parameter int LEVEL_W = 4
) (
    input  logic               enable,
    input  logic [LEVEL_W-1:0] level,
    input  logic [LEVEL_W-1:0] slot,
    output logic               on
);
    assign on = enable && (level > slot);
endmodule

// File: rtl/ledmx_refresh.sv
module ledmx_refresh #(
    parameter int ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] PTR_ADDR = 'h1A,
    parameter int ROWS     = 5,
    parameter int COLS     = 5,
    parameter int LEVEL_W  = 4,
    parameter int PRESCALE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic [ROWS-1:0]   row_en,
    output logic [COLS-1:0]   col_on
);
    localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int ROW_CYCLES = (2 ** LEVEL_W) * PRESCALE;

    logic                    take, shadow_full, lit;
    logic [ROW_W-1:0]        shadow_row;
    logic [COLS*LEVEL_W-1:0] shadow_lvl, active_lvl;
    logic [LEVEL_W-1:0]      slot;

    ledmx_fetch #(
        .ADDR_W(ADDR_W), .PTR_ADDR(PTR_ADDR), .ROWS(ROWS),
        .COLS(COLS), .LEVEL_W(LEVEL_W), .ROW_W(ROW_W)
    ) i_fetch (
        .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .take(take), .shadow_full(shadow_full),
        .shadow_row(shadow_row), .shadow_lvl(shadow_lvl)
    );

    ledmx_scan #(
        .ROWS(ROWS), .COLS(COLS), .LEVEL_W(LEVEL_W),
        .PRESCALE(PRESCALE), .ROW_W(ROW_W)
    ) i_scan (
        .clk(clk), .rst_n(rst_n), .shadow_full(shadow_full),
        .shadow_row(shadow_row), .shadow_lvl(shadow_lvl),
        .take(take), .lit(lit), .slot(slot),
        .active_lvl(active_lvl), .row_en(row_en)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_col
        ledmx_cell_pwm #(.LEVEL_W(LEVEL_W)) i_pwm (
            .enable(lit),
            .level(active_lvl[c*LEVEL_W +: LEVEL_W]),
            .slot(slot),
            .on(col_on[c])
        );
    end

endmodule

// File: rtl/ledmx_refresh_chk.sv
module ledmx_refresh_chk #(
    parameter int ROWS    = 5,
    parameter int COLS    = 5,
    parameter int ROW_CYC = 1024
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_busy,
    input logic            mem_req,
    input logic [ROWS-1:0] row_en,
    input logic [COLS-1:0] col_on
);
    logic [ROWS-1:0] last_q;
    int unsigned     age_q, age_now;

    assign age_now = (row_en != last_q) ? 0 : age_q + 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            age_q  <= 0;
        end else begin
            last_q <= row_en;
            age_q  <= age_now;
        end
    end

    // R7
    yield_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_busy |-> !mem_req);

    // R6
    one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_en));

    // R6
    dark_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en == '0) |-> (col_on == '0));

    // R5
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en != '0 && age_now < ROW_CYC - 1) |=> $stable(row_en));

    // R5
    row_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en != '0 && age_now == ROW_CYC - 1) |=> (row_en != $past(row_en)));

endmodule

bind ledmx_refresh ledmx_refresh_chk #(
    .ROWS(ROWS), .COLS(COLS), .ROW_CYC(ROW_CYCLES)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy),
    .mem_req(mem_req), .row_en(row_en), .col_on(col_on)
);

// File: tb/test_ledmx_refresh.sv
module test_ledmx_refresh;
    localparam int ROWS = 5;
    localparam int COLS = 5;
    localparam int PRESC = 4;
    localparam int ROW_CYC = 16 * PRESC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cpu_busy = 1'b0;
    logic            mem_req;
    logic [7:0]      mem_addr;
    logic [7:0]      mem_rdata = '0;
    logic [ROWS-1:0] row_en;
    logic [COLS-1:0] col_on;
    logic [ROWS-1:0] prev_row = '0;
    logic [7:0]      mem [256];

    int checks = 0;
    int errors = 0;
    int busy_reqs = 0;

    always #10 clk = ~clk;

    ledmx_refresh #(.PRESCALE(PRESC)) i_ledmx_refresh (
        .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .row_en(row_en), .col_on(col_on)
    );

    // memory model: data one cycle after an accepted request (R7)
    always @(posedge clk) begin
        prev_row <= row_en;
        if (mem_req) mem_rdata <= mem[mem_addr];
        if (mem_req && cpu_busy) busy_reqs <= busy_reqs + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int level_of(input int base, input int r, input int c);
        return int'(mem[8'(base + 5 * r + c)][3:0]);
    endfunction

    task automatic wait_entry(input int r);
        do @(negedge clk);
        while (!(row_en == ROWS'(1 << r) && prev_row != ROWS'(1 << r)));
    endtask

    // R3 R4 R5: one full row visit from its first cycle
    task automatic check_row(input int r, input int base);
        int on_cnt [COLS];
        int off_row = 0;
        wait_entry(r);
        for (int c = 0; c < COLS; c++) on_cnt[c] = 0;
        for (int i = 0; i < ROW_CYC; i++) begin
            if (i > 0) @(negedge clk);
            if (row_en != ROWS'(1 << r)) off_row++;
            for (int c = 0; c < COLS; c++) if (col_on[c]) on_cnt[c]++;
        end
        chk(off_row == 0, "R5 row held", off_row, 0);
        for (int c = 0; c < COLS; c++)
            chk(on_cnt[c] == level_of(base, r, c) * PRESC, "R3/R4 column on-time",
                on_cnt[c], level_of(base, r, c) * PRESC);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(row_en == '0, "R1 row_en", int'(row_en), 0);
        chk(col_on == '0, "R1 col_on", int'(col_on), 0);
        chk(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_frame();
        for (int r = 0; r < ROWS; r++) check_row(r, 'h00);
    endtask

    // R2: pointer moved during row 1
    task automatic t_move_pointer();
        wait_entry(1);
        mem['h1A] = 8'h40;
        for (int r = 2; r < ROWS; r++) check_row(r, 'h00);
        for (int r = 0; r < ROWS; r++) check_row(r, 'h40);
    endtask

    // R8 R7: CPU takes the port from the first cycle of row 1
    task automatic t_starve();
        int start_reqs;
        int first;
        wait_entry(1);
        cpu_busy = 1'b1;
        start_reqs = busy_reqs;
        repeat (ROW_CYC + 40) @(negedge clk);
        chk(row_en == '0, "R8 dark while starved", int'(row_en), 0);
        chk(col_on == '0, "R8 columns dark", int'(col_on), 0);
        chk(busy_reqs == start_reqs, "R7 no read while busy", busy_reqs - start_reqs, 0);
        cpu_busy = 1'b0;
        do @(negedge clk); while (row_en == '0);
        first = int'(row_en);
        chk(row_en == ROWS'(1 << 2), "R8 resumes with starved row", first, 1 << 2);
        check_row(3, 'h40);
        check_row(4, 'h40);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
        for (int i = 5; i < 25; i++) mem[i] = {4'(i), 4'((i * 3) % 16)};
        mem[0] = 8'hF0; mem[1] = 8'h0F; mem[2] = 8'hA7; mem[3] = 8'h31; mem[4] = 8'h08;
        for (int i = 0; i < 25; i++) mem['h40 + i] = {4'hC, 4'(15 - i)};
        mem['h1A] = 8'h00;
        t_reset();
        t_first_frame();
        t_move_pointer();
        t_starve();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule